// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns one externally supplied start address into the four addresses of a burst. A load captures the whole input address and presents it on the output. Each later advance produces the next beat address: the bits above the two lowest stay frozen, and the two lowest bits step through one of two orders. A static order input chooses the order. The first order counts upward and wraps modulo four. The second order XORs the start bits with a beat count.

The block sits in front of a pipelined synchronous memory array or a memory controller. A request with load/advance select at 0 starts a burst. Requests with the select at 1 walk through that burst without presenting the address again. Two inputs gate every operation. When clock enable is low, the whole block freezes. When the valid qualifier is low for a cycle, that cycle does nothing. The output is registered, so an operation sampled on a rising edge is visible on the output after that same edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous reset is high, the burst address output, the stored start address and the beat count all clear to zero. An advance right after reset in order 0 therefore yields address 1.
- R2: A rising edge with clk_en=1, start_vld=1 and adv_sel=0 is a load. After that edge burst_addr equals addr_in, and the beat count restarts at 0.
- R3: With order_ilv=0 (wrap order), the advance that completes beat k (k=1,2,3) outputs low bits equal to (start low bits + k) modulo 4. For example, start 1 gives 1,2,3,0.
- R4: With order_ilv=1 (XOR order), the advance that completes beat k outputs low bits equal to (start low bits) XOR k. For example, start 1 gives 1,0,3,2.
- R5: During advances, bits AW-1 down to 2 of burst_addr stay equal to those bits of the loaded address.
- R6: The fourth advance returns the output to the loaded address. Further advances repeat the same four-beat sequence.
- R7: A rising edge with clk_en=0 changes nothing. The output holds, and a following advance continues from the beat reached before the pause, whatever adv_sel, start_vld and addr_in showed meanwhile.
- R8: A rising edge with clk_en=1 and start_vld=0 changes nothing. The output holds, and neither a load nor an advance takes place.
- R9: addr_in is ignored on an advance. Only the loaded address and the beat count set the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = operate this edge, 0 = freeze everything |
| start_vld | input | 1 | 1 = perform the load or advance chosen by adv_sel |
| adv_sel | input | 1 | 0 = load addr_in, 1 = advance to next beat |
| order_ilv | input | 1 | Static order: 0 = wrap-around count, 1 = XOR with beat count |
| addr_in | input | AW | External start address |
| burst_addr | output | AW | Registered current beat address |

## Verification
The step-by-step assertions assume that order_ilv only changes right before a load. They therefore require the same order on the edge that made the current output and on the edge that advances it. Mid-burst order changes are left undefined. The directed stimulus keeps this rule: the order is set only in the cycle that drives a load, and it is then held through every advance, pause and idle cycle of that burst. Inputs are driven on falling edges, so each rising edge samples settled values that the assertions can relate to the following cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADV  = 2'd2
  } bseq_op_e;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } bseq_order_e;

  function automatic bseq_op_e bseq_decode(input logic en, input logic vld, input logic adv);
    if (!(en && vld)) return OP_IDLE;
    return adv ? OP_ADV : OP_LOAD;
  endfunction

endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned LB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  bseq_op_e      op,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base_q,
  output logic [LB-1:0] beat_q,
  output logic [LB-1:0] beat_nx
);

  assign beat_nx = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          base_q <= addr_in;
          beat_q <= '0;
        end
        OP_ADV:  beat_q <= beat_nx;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bseq_order_gen.sv
module bseq_order_gen
  import bseq_pkg::*;
#(
  parameter int unsigned LB = 2
) (
  input  logic [LB-1:0] start_lo,
  input  logic [LB-1:0] beat,
  input  bseq_order_e   order,
  output logic [LB-1:0] lo
);

  logic [LB-1:0] wrap_lo;
  logic [LB-1:0] xor_lo;

  assign wrap_lo = start_lo + beat;

  for (genvar b = 0; b < LB; b++) begin : g_xor_bit
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign lo = (order == ORD_XOR) ? xor_lo : wrap_lo;

endmodule

// File: rtl/bseq_out_reg.sv
module bseq_out_reg
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned LB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  bseq_op_e      op,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] base_q,
  input  logic [LB-1:0] step_lo,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= addr_in;
        OP_ADV:  q <= {base_q[AW-1:LB], step_lo};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          start_vld,
  input  logic          adv_sel,
  input  logic          order_ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] burst_addr
);

  localparam int unsigned LB = $clog2(BURST_BEATS);

  bseq_op_e      op;
  bseq_order_e   order;
  logic [AW-1:0] base_q;
  logic [LB-1:0] beat_q;
  logic [LB-1:0] beat_nx;
  logic [LB-1:0] step_lo;

  assign op    = bseq_decode(clk_en, start_vld, adv_sel);
  assign order = bseq_order_e'(order_ilv);

  bseq_base_reg #(.AW(AW), .LB(LB)) u_base (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .addr_in (addr_in),
    .base_q  (base_q),
    .beat_q  (beat_q),
    .beat_nx (beat_nx)
  );

  bseq_order_gen #(.LB(LB)) u_order (
    .start_lo (base_q[LB-1:0]),
    .beat     (beat_nx),
    .order    (order),
    .lo       (step_lo)
  );

  bseq_out_reg #(.AW(AW), .LB(LB)) u_out (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .addr_in (addr_in),
    .base_q  (base_q),
    .step_lo (step_lo),
    .q       (burst_addr)
  );

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int unsigned AW = 19,
  parameter int unsigned LB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en,
  input logic          start_vld,
  input logic          adv_sel,
  input logic          order_ilv,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] burst_addr
);

  // R2: a load presents the sampled address
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start_vld && !adv_sel) |=> burst_addr == $past(addr_in));

  // R5 and R9: advances keep the upper bits whatever addr_in shows
  a_r5_upper_frozen: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start_vld && adv_sel) |=> burst_addr[AW-1:LB] == $past(burst_addr[AW-1:LB]));

  // R7: clock enable low freezes the output
  a_r7_hold_en: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(burst_addr));

  // R8: no valid, no change
  a_r8_hold_vld: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !start_vld) |=> $stable(burst_addr));

  // R3 and R6: wrap order steps the low bits by one modulo the burst length
  a_r3_wrap_step: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start_vld && adv_sel && !order_ilv && !$past(order_ilv))
    |=> burst_addr[LB-1:0] == LB'($past(burst_addr[LB-1:0]) + 1'b1));

  // R4: XOR order never repeats the low bits on consecutive beats
  a_r4_xor_moves: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start_vld && adv_sel && order_ilv && $past(order_ilv))
    |=> burst_addr[LB-1:0] != $past(burst_addr[LB-1:0]));

endmodule

bind burst_addr_seq bseq_checker #(.AW(AW), .LB(LB)) u_bseq_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .start_vld  (start_vld),
  .adv_sel    (adv_sel),
  .order_ilv  (order_ilv),
  .addr_in    (addr_in),
  .burst_addr (burst_addr)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int unsigned AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          start_vld = 1'b0;
  logic          adv_sel = 1'b0;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] burst_addr;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .BURST_BEATS(4)) i_burst_addr_seq (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .start_vld  (start_vld),
    .adv_sel    (adv_sel),
    .order_ilv  (order_ilv),
    .addr_in    (addr_in),
    .burst_addr (burst_addr)
  );

  function automatic logic [1:0] exp_lo(input logic ilv, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k);
    return ilv ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (burst_addr !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, burst_addr, exp);
    end
  endtask

  // drive on the falling edge, let one rising edge pass, return at the next falling edge
  task automatic cycle(input logic en, input logic vld, input logic adv, input logic [AW-1:0] a);
    clk_en = en; start_vld = vld; adv_sel = adv; addr_in = a;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycle(1'b1, 1'b1, 1'b0, 19'h5A5A5);
    cycle(1'b1, 1'b1, 1'b0, 19'h5A5A5);
    rst = 1'b0;
    check("R1 reset clears output", '0);
    order_ilv = 1'b0;
    cycle(1'b1, 1'b1, 1'b1, 19'h7FFFF);
    check("R1 advance after reset from zero", 19'h00001);
  endtask

  // eight advances: two full passes, addr_in scrambled on each advance
  task automatic t_burst(input logic ilv, input logic [AW-1:0] start);
    order_ilv = ilv;
    cycle(1'b1, 1'b1, 1'b0, start);
    check("R2 load", start);
    for (int k = 1; k <= 8; k++) begin
      cycle(1'b1, 1'b1, 1'b1, start ^ 19'(k * 12345));
      check(ilv ? "R4 R5 R6 R9 xor beat" : "R3 R5 R6 R9 wrap beat",
            {start[AW-1:2], exp_lo(ilv, start[1:0], k)});
    end
  endtask

  task automatic t_pause_en;
    logic [AW-1:0] s;
    s = 19'h2468B;
    order_ilv = 1'b1;
    cycle(1'b1, 1'b1, 1'b0, s);
    cycle(1'b1, 1'b1, 1'b1, '0);
    check("R7 before pause", {s[AW-1:2], exp_lo(1'b1, s[1:0], 1)});
    cycle(1'b0, 1'b1, 1'b0, 19'h11111);
    check("R7 load blocked", {s[AW-1:2], exp_lo(1'b1, s[1:0], 1)});
    cycle(1'b0, 1'b1, 1'b1, 19'h22222);
    check("R7 advance blocked", {s[AW-1:2], exp_lo(1'b1, s[1:0], 1)});
    cycle(1'b1, 1'b1, 1'b1, 19'h33333);
    check("R7 resume beat 2", {s[AW-1:2], exp_lo(1'b1, s[1:0], 2)});
  endtask

  task automatic t_no_valid;
    logic [AW-1:0] s;
    s = 19'h13572;
    order_ilv = 1'b0;
    cycle(1'b1, 1'b1, 1'b0, s);
    cycle(1'b1, 1'b0, 1'b0, 19'h44444);
    check("R8 load without valid", s);
    cycle(1'b1, 1'b0, 1'b1, 19'h55555);
    check("R8 advance without valid", s);
    cycle(1'b1, 1'b1, 1'b1, 19'h66666);
    check("R8 first real advance", {s[AW-1:2], exp_lo(1'b0, s[1:0], 1)});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_burst(1'b0, 19'h3A5C0 | 19'(s));
      t_burst(1'b1, 19'h0C3F0 | 19'(s));
    end
    t_burst(1'b0, 19'h7FFFF);
    t_burst(1'b1, 19'h40002);
    t_pause_en();
    t_no_valid();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule